// File: doc/BRIEF.md
# Sprite Attribute RAM Copy Engine with CPU Bus Lockout

The engine fills the 160-byte sprite attribute RAM from a 256-byte-aligned source page. A start pulse carries the page number. The engine then reads the page through a byte-read port and writes each byte into sprite RAM, spacing the bytes at a fixed interval.

While a copy is running, the engine drives a lockout flag for the CPU address currently on the bus. The surrounding memory system uses that flag to return 0xFF on reads and to drop writes. The locked window depends on the bus that the source page lives on, and it differs between the older monochrome model and the colour model. The `color_model_i` pin selects which table applies.

Read data is taken combinationally in the copy cycle and passed straight to the sprite RAM write port.

Top module: `oam_dma`

## Requirements
- R1: During and directly after reset, `busy_o`, `spr_we_o` and `cpu_block_o` are all 0.
- R2: A start whose base address `{src_page_i, 8'h00}` is above 0xF100 is ignored. Page 0xF2 and higher start nothing, and page 0xF1 is accepted.
- R3: An accepted start copies exactly 160 bytes. The n-th write (n = 0..159) goes to `spr_waddr_o` = n and reads `rd_addr_o` = base + n. No write strobe occurs while idle.
- R4: With the start sampled at clock edge E0, the first write strobe is high in the cycle before edge E8, where it commits. Each further strobe comes exactly 4 cycles after the previous one.
- R5: `spr_wdata_o` equals `rd_data_i` in every cycle where `spr_we_o` is high.
- R6: While busy, CPU addresses 0xFE00 to 0xFE9F are always locked.
- R7: When `color_model_i` = 0 and busy, the locked window is selected by the source index `base[15:13]`. Index 4 locks 0x8000 to 0x9FFF. Every other index locks 0xA000 to 0xFDFF.
- R8: When `color_model_i` = 1 and busy, index 4 locks 0x8000 to 0x9FFF and index 6 locks 0xC000 to 0xFDFF. Every other index locks 0xA000 to 0xBFFF.
- R9: `busy_o` and every lock drop right after the edge that commits the 160th byte. While idle, `cpu_block_o` is 0.
- R10: A valid start while busy restarts the copy from the new page, with the R4 timing. A start that is invalid under R2 while busy leaves the running copy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| color_model_i | input | 1 | 1 selects the colour-model lockout table |
| start_i | input | 1 | Start pulse |
| src_page_i | input | 8 | Source page number (high address byte) |
| rd_req_o | output | 1 | Source read strobe |
| rd_addr_o | output | 16 | Source read address |
| rd_data_i | input | 8 | Source read data, same cycle |
| spr_we_o | output | 1 | Sprite RAM write enable |
| spr_waddr_o | output | 8 | Sprite RAM byte offset |
| spr_wdata_o | output | 8 | Sprite RAM write data |
| busy_o | output | 1 | Copy in progress |
| cpu_addr_i | input | 16 | Current CPU access address |
| cpu_block_o | output | 1 | CPU access must read 0xFF and drop writes |

## Verification
Two things can meet in the same cycle: a new start and an in-flight copy. The bench therefore issues a second valid page part-way through a copy. It then checks that the write count, addresses and first-byte spacing all restart from the new page, and that no stray byte from the old page is counted. In a separate test, an out-of-range page is issued mid-copy and must leave the original sequence intact. The other overlap is the lockout decode against the final byte. The bench probes a locked address in the last strobe cycle and in the cycle after it, and expects the lock to be held, then released.

// File: rtl/oam_dma_pkg.sv
package oam_dma_pkg;
  localparam logic [15:0] SPR_LO = 16'hFE00;
  localparam logic [15:0] SPR_HI = 16'hFEA0;

  typedef struct packed {
    logic [15:0] lo;
    logic [15:0] hi;
  } span_t;

  // lock window, half-open [lo, hi), chosen by source bits [15:13]
  function automatic span_t lock_span(input logic [2:0] idx, input logic color);
    span_t s;
    if (idx == 3'd4) begin
      s.lo = 16'h8000; s.hi = 16'hA000;
    end else if (!color) begin
      s.lo = 16'hA000; s.hi = 16'hFE00;
    end else if (idx == 3'd6) begin
      s.lo = 16'hC000; s.hi = 16'hFE00;
    end else begin
      s.lo = 16'hA000; s.hi = 16'hC000;
    end
    return s;
  endfunction
endpackage

// File: rtl/oam_dma_seq.sv
module oam_dma_seq #(
  parameter int          XFER_LEN  = 160,
  parameter int          FIRST_GAP = 8,
  parameter int          BYTE_GAP  = 4,
  parameter logic [15:0] MAX_BASE  = 16'hF100,
  localparam int         OAM_AW    = $clog2(XFER_LEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [7:0]        src_page_i,
  output logic              busy_o,
  output logic              copy_o,
  output logic [15:0]       src_o,
  output logic [OAM_AW-1:0] dst_o
);
  localparam int CNT_W = $clog2(XFER_LEN + 1);
  localparam int GAP_W = $clog2(FIRST_GAP + BYTE_GAP);

  logic [15:0]      base;
  logic             accept;
  logic [CNT_W-1:0] remain_q;
  logic [GAP_W-1:0] wait_q;

  assign base   = {src_page_i, 8'h00};
  assign accept = start_i && (base <= MAX_BASE);
  assign copy_o = busy_o && (wait_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o   <= 1'b0;
      src_o    <= '0;
      dst_o    <= '0;
      remain_q <= '0;
      wait_q   <= '0;
    end else if (accept) begin
      busy_o   <= 1'b1;
      src_o    <= base;
      dst_o    <= '0;
      remain_q <= CNT_W'(XFER_LEN);
      wait_q   <= GAP_W'(FIRST_GAP - 1);
    end else if (busy_o) begin
      if (copy_o) begin
        src_o    <= src_o + 16'd1;
        dst_o    <= dst_o + OAM_AW'(1);
        remain_q <= remain_q - CNT_W'(1);
        wait_q   <= GAP_W'(BYTE_GAP - 1);
        if (remain_q == CNT_W'(1)) busy_o <= 1'b0;
      end else begin
        wait_q <= wait_q - GAP_W'(1);
      end
    end
  end
endmodule

// File: rtl/oam_dma_guard.sv
module oam_dma_guard
  import oam_dma_pkg::*;
(
  input  logic        busy_i,
  input  logic [2:0]  src_idx_i,
  input  logic        color_i,
  input  logic [15:0] cpu_addr_i,
  output logic        block_o
);
  span_t span;
  logic  in_spr, in_span;

  always_comb begin
    span    = lock_span(src_idx_i, color_i);
    in_spr  = (cpu_addr_i >= SPR_LO) && (cpu_addr_i < SPR_HI);
    in_span = (cpu_addr_i >= span.lo) && (cpu_addr_i < span.hi);
    block_o = busy_i && (in_spr || in_span);
  end
endmodule

// File: rtl/oam_dma.sv
module oam_dma #(
  parameter int          XFER_LEN  = 160,
  parameter int          FIRST_GAP = 8,
  parameter int          BYTE_GAP  = 4,
  parameter logic [15:0] MAX_BASE  = 16'hF100,
  localparam int         OAM_AW    = $clog2(XFER_LEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              color_model_i,
  input  logic              start_i,
  input  logic [7:0]        src_page_i,
  output logic              rd_req_o,
  output logic [15:0]       rd_addr_o,
  input  logic [7:0]        rd_data_i,
  output logic              spr_we_o,
  output logic [OAM_AW-1:0] spr_waddr_o,
  output logic [7:0]        spr_wdata_o,
  output logic              busy_o,
  input  logic [15:0]       cpu_addr_i,
  output logic              cpu_block_o
);
  logic              copy;
  logic [15:0]       src;
  logic [OAM_AW-1:0] dst;

  oam_dma_seq #(
    .XFER_LEN (XFER_LEN),
    .FIRST_GAP(FIRST_GAP),
    .BYTE_GAP (BYTE_GAP),
    .MAX_BASE (MAX_BASE)
  ) i_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .src_page_i(src_page_i),
    .busy_o    (busy_o),
    .copy_o    (copy),
    .src_o     (src),
    .dst_o     (dst)
  );

  oam_dma_guard i_guard (
    .busy_i    (busy_o),
    .src_idx_i (src[15:13]),
    .color_i   (color_model_i),
    .cpu_addr_i(cpu_addr_i),
    .block_o   (cpu_block_o)
  );

  assign rd_req_o    = copy;
  assign rd_addr_o   = src;
  assign spr_we_o    = copy;
  assign spr_waddr_o = dst;
  assign spr_wdata_o = rd_data_i;
endmodule

// File: rtl/oam_dma_chk.sv
module oam_dma_chk #(
  parameter int OAM_AW = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [7:0]        src_page_i,
  input logic [15:0]       cpu_addr_i,
  input logic              busy_o,
  input logic              spr_we_o,
  input logic [OAM_AW-1:0] spr_waddr_o,
  input logic [15:0]       rd_addr_o,
  input logic              cpu_block_o
);
  assert_no_write_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spr_we_o |-> busy_o);

  assert_addr_pair_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spr_we_o |-> (rd_addr_o[OAM_AW-1:0] == spr_waddr_o));

  assert_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spr_we_o |=> !spr_we_o);

  assert_bad_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && src_page_i > 8'hF1) |=> !busy_o);

  assert_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && src_page_i <= 8'hF1) |=> (busy_o && !spr_we_o));

  assert_spr_lock_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cpu_addr_i >= 16'hFE00 && cpu_addr_i <= 16'hFE9F) |-> cpu_block_o);

  assert_idle_open_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !cpu_block_o);
endmodule

bind oam_dma oam_dma_chk #(.OAM_AW(OAM_AW)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .src_page_i (src_page_i),
  .cpu_addr_i (cpu_addr_i),
  .busy_o     (busy_o),
  .spr_we_o   (spr_we_o),
  .spr_waddr_o(spr_waddr_o),
  .rd_addr_o  (rd_addr_o),
  .cpu_block_o(cpu_block_o)
);

// File: tb/test_oam_dma.sv
module test_oam_dma;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        color_model_i = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  src_page_i = 8'h00;
  logic        rd_req_o;
  logic [15:0] rd_addr_o;
  logic [7:0]  rd_data_i;
  logic        spr_we_o;
  logic [7:0]  spr_waddr_o;
  logic [7:0]  spr_wdata_o;
  logic        busy_o;
  logic [15:0] cpu_addr_i = 16'h0000;
  logic        cpu_block_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int wcount, first_cyc, last_cyc, gap_err, addr_err, data_err;
  logic [15:0] exp_base;

  always #10ns clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic logic [7:0] mem_fn(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  assign rd_data_i = mem_fn(rd_addr_o);

  oam_dma i_oam_dma (.*);

  always @(negedge clk_i) begin
    if (spr_we_o) begin
      if (wcount == 0) first_cyc = cyc;
      else if (cyc - last_cyc != 4) gap_err++;
      if (spr_waddr_o != wcount[7:0]) addr_err++;
      if (rd_addr_o != exp_base + 16'(wcount)) addr_err++;
      if (spr_wdata_o != mem_fn(rd_addr_o)) data_err++;
      last_cyc = cyc;
      wcount++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_block(input logic [7:0] page, input logic color,
                                     input logic [15:0] a);
    logic [15:0] lo, hi;
    if (a >= 16'hFE00 && a <= 16'hFE9F) return 1'b1;
    if (page[7:5] == 3'd4) begin lo = 16'h8000; hi = 16'hA000; end
    else if (!color)       begin lo = 16'hA000; hi = 16'hFE00; end
    else if (page[7:5] == 3'd6) begin lo = 16'hC000; hi = 16'hFE00; end
    else                   begin lo = 16'hA000; hi = 16'hC000; end
    return (a >= lo) && (a < hi);
  endfunction

  task automatic start_xfer(input logic [7:0] page, output int s);
    @(posedge clk_i); #1;
    wcount = 0; gap_err = 0; addr_err = 0; data_err = 0; first_cyc = -1;
    exp_base = {page, 8'h00};
    @(negedge clk_i); start_i = 1'b1; src_page_i = page;
    @(posedge clk_i); #1; s = cyc; start_i = 1'b0;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 5000 && busy_o; n++) @(negedge clk_i);
  endtask

  task automatic t_reset();
    cpu_addr_i = 16'hFE00;
    #5ns;
    chk("R1 busy in reset", busy_o, 0);
    chk("R1 we in reset", spr_we_o, 0);
    chk("R1 block in reset", cpu_block_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 busy after reset", busy_o, 0);
    chk("R1 block after reset", cpu_block_o, 0);
  endtask

  task automatic t_full(input logic [7:0] page);
    int s;
    start_xfer(page, s);
    wait_idle();
    chk("R3 byte count", wcount, 160);
    chk("R4 first strobe cycle", first_cyc, s + 7);
    chk("R4 byte spacing errors", gap_err, 0);
    chk("R3 address errors", addr_err, 0);
    chk("R5 data errors", data_err, 0);
  endtask

  task automatic t_end();
    int s;
    cpu_addr_i = 16'hFE10;
    start_xfer(8'h40, s);
    while (cyc != s + 643) @(negedge clk_i);
    chk("R9 busy at last byte", busy_o, 1);
    chk("R9 block at last byte", cpu_block_o, 1);
    chk("R9 strobe at last byte", spr_we_o, 1);
    @(negedge clk_i);
    chk("R9 busy after last byte", busy_o, 0);
    chk("R9 block after last byte", cpu_block_o, 0);
    chk("R9 byte count", wcount, 160);
  endtask

  task automatic t_ignore();
    int s;
    start_xfer(8'hF2, s);
    @(negedge clk_i);
    chk("R2 page F2 not started", busy_o, 0);
    repeat (20) @(negedge clk_i);
    chk("R2 page F2 no writes", wcount, 0);
    cpu_addr_i = 16'hFE00; #1;
    chk("R2 no lock when ignored", cpu_block_o, 0);
    t_full(8'hF1);
  endtask

  task automatic t_table(input logic color);
    logic [15:0] probes[12] = '{16'h0000, 16'h7FFF, 16'h8000, 16'h9FFF, 16'hA000,
                                16'hBFFF, 16'hC000, 16'hFDFF, 16'hFE00, 16'hFE9F,
                                16'hFEA0, 16'hFF80};
    int s;
    color_model_i = color;
    for (int idx = 0; idx < 8; idx++) begin
      logic [7:0] page;
      page = {3'(idx), 5'd0};
      start_xfer(page, s);
      for (int k = 0; k < 12; k++) begin
        @(negedge clk_i); cpu_addr_i = probes[k]; #1;
        chk(color ? "R8 colour table" : "R7 older table",
            cpu_block_o, int'(exp_block(page, color, probes[k])));
      end
      wait_idle();
    end
    color_model_i = 1'b0;
  endtask

  task automatic t_restart();
    int s;
    start_xfer(8'h12, s);
    repeat (20) @(posedge clk_i);
    start_xfer(8'h34, s);
    wait_idle();
    chk("R10 restart count", wcount, 160);
    chk("R10 restart first strobe", first_cyc, s + 7);
    chk("R10 restart addresses", addr_err, 0);
    chk("R10 restart spacing", gap_err, 0);
  endtask

  task automatic t_bad_mid();
    int s;
    start_xfer(8'h20, s);
    repeat (21) @(negedge clk_i);
    start_i = 1'b1; src_page_i = 8'hFF;
    @(negedge clk_i); start_i = 1'b0;
    wait_idle();
    chk("R10 invalid mid start count", wcount, 160);
    chk("R10 invalid mid start addresses", addr_err, 0);
    chk("R10 invalid mid start spacing", gap_err, 0);
  endtask

  initial begin
    #(20ns * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wcount = 0; gap_err = 0; addr_err = 0; data_err = 0; first_cyc = -1; last_cyc = 0;
    exp_base = 16'h0000;
    t_reset();
    t_full(8'hC1);
    t_full(8'h00);
    t_end();
    t_ignore();
    t_table(1'b0);
    t_table(1'b1);
    t_restart();
    t_bad_mid();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule